// File: doc/BRIEF.md
# FIFO-fed CPU bootstrap bridge

This block is the glue between an 8-bit microprocessor and a byte-stream FIFO. It lets the processor boot and run code that arrives over the stream, so no ROM is needed. The top quarter of the 16-bit address space is the FIFO window. When the processor reads there, the bridge pops one byte and places it on the data bus. Addresses in the quarter below the window select RAM. Everything below that selects nothing.

The processor's ready input follows the stream's valid flag directly, so the processor waits whenever no byte is queued. A host can therefore feed an instruction stream one byte at a time.

A write to RAM does not consume the queued byte. It stays in place and becomes the next opcode, fetched by the next read in the window. The reset vector fetch also lands in the window. A stream that starts with two 0xEA bytes therefore produces a vector of 0xEAEA, and that address is itself in the window.

The bus model has two phases. The address and the read/write level are sampled at a clock edge. The data-bus outputs and the RAM select are registered and apply in the following cycle.

Top module: `fifo_boot_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, drive_en and ram_sel are 0 and bus_dout is 0x00.
- R2: cpu_ready equals strm_valid in every cycle, with no delay.
- R3: strm_pop is 1 in a cycle exactly when cpu_rd is 1, cpu_addr is at or above 0xC000, and strm_valid is 1. The pop is one clock wide and never occurs while cpu_ready is 0.
- R4: In the cycle after a pop, drive_en is 1 and bus_dout equals the strm_data value presented in the pop cycle.
- R5: drive_en is 0 in any cycle that does not follow a pop. Write cycles, RAM-region cycles and cycles below 0x8000 cause no pop.
- R6: ram_sel is 1 in the cycle after a cycle whose address lies in 0x8000..0xBFFF, for reads and writes alike. It is 0 after any other address.
- R7: A window read held while strm_valid is 0 pops nothing and leaves drive_en at 0. Once strm_valid rises, exactly one pop delivers the byte.
- R8: Reads at 0xFFFC and 0xFFFD with stream bytes 0xEA, 0xEA return 0xEA twice. The assembled vector 0xEAEA decodes into the window, and a read there pops the next byte.
- R9: A byte queued during a RAM write cycle is not consumed by that cycle. The following window read pops it and returns it on bus_dout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one processor bus cycle per clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address bus |
| cpu_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| strm_valid | input | 1 | Stream has at least one byte queued |
| strm_data | input | 8 | Byte at the head of the stream |
| strm_pop | output | 1 | One-clock strobe removing the head byte |
| cpu_ready | output | 1 | Ready to the processor; low stalls it |
| bus_dout | output | 8 | Data driven to the processor data bus |
| drive_en | output | 1 | Data-bus drive enable; 0 = released |
| ram_sel | output | 1 | RAM chip select, active high |

## Verification
The bench uses the default build: a 16-bit address, 8-bit data, the window at 0xC000 and RAM at 0x8000..0xBFFF. With a 16-bit address every address can be swept. The bench reads all 65536 addresses with a byte queued. It also sweeps write cycles and empty-stream reads over strided addresses. This covers every decode boundary, including 0x7FFF/0x8000 and 0xBFFF/0xC000. Directed sequences then cover the stall release, the 0xEAEA reset vector, and a queued opcode surviving a RAM store.

// File: rtl/fbb_pkg.sv
package fbb_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_WIN  = 2'd2
  } region_e;

endpackage

// File: rtl/fbb_decode.sv
module fbb_decode
  import fbb_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] WIN_LO  = 16'hC000,
  parameter logic [ADDR_W-1:0] RAM_LO  = 16'h8000,
  parameter logic [ADDR_W-1:0] RAM_HI  = 16'hBFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);

  always_comb begin
    if (addr >= WIN_LO)
      region = RGN_WIN;
    else if (addr >= RAM_LO && addr <= RAM_HI)
      region = RGN_RAM;
    else
      region = RGN_NONE;
  end

endmodule

// File: rtl/fbb_read_port.sv
module fbb_read_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_rd,
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  output logic              pop,
  output logic [DATA_W-1:0] dout_q,
  output logic              oe_q
);

  assign pop = win_rd & valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= pop;
      if (pop) dout_q <= data;
    end
  end

  // R3: a pop only ever happens with a byte waiting
  a_r3_pop_has_data: assert property (@(posedge clk) disable iff (rst)
    pop |-> valid);

  // R4: the cycle after a pop drives the captured byte
  a_r4_drive_after_pop: assert property (@(posedge clk) disable iff (rst)
    pop |=> (oe_q && dout_q == $past(data)));

  // R5: no pop, no drive in the next cycle
  a_r5_idle_release: assert property (@(posedge clk) disable iff (rst)
    !pop |=> !oe_q);

endmodule

// File: rtl/fifo_boot_bridge.sv
module fifo_boot_bridge
  import fbb_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter int                DATA_W = 8,
  parameter logic [ADDR_W-1:0] WIN_LO = 16'hC000,
  parameter logic [ADDR_W-1:0] RAM_LO = 16'h8000,
  parameter logic [ADDR_W-1:0] RAM_HI = 16'hBFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              strm_valid,
  input  logic [DATA_W-1:0] strm_data,
  output logic              strm_pop,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] bus_dout,
  output logic              drive_en,
  output logic              ram_sel
);

  region_e rgn;
  logic    win_rd;
  logic    ram_sel_q;

  fbb_decode #(
    .ADDR_W (ADDR_W),
    .WIN_LO (WIN_LO),
    .RAM_LO (RAM_LO),
    .RAM_HI (RAM_HI)
  ) u_decode (
    .addr   (cpu_addr),
    .region (rgn)
  );

  assign win_rd    = cpu_rd && (rgn == RGN_WIN);
  assign cpu_ready = strm_valid;

  fbb_read_port #(
    .DATA_W (DATA_W)
  ) u_rport (
    .clk    (clk),
    .rst    (rst),
    .win_rd (win_rd),
    .valid  (strm_valid),
    .data   (strm_data),
    .pop    (strm_pop),
    .dout_q (bus_dout),
    .oe_q   (drive_en)
  );

  always_ff @(posedge clk) begin
    if (rst) ram_sel_q <= 1'b0;
    else     ram_sel_q <= (rgn == RGN_RAM);
  end

  assign ram_sel = ram_sel_q;

  // R3: the pop is never issued while the processor is stalled
  a_r3_pop_not_stalled: assert property (@(posedge clk) disable iff (rst)
    strm_pop |-> cpu_ready);

  // R5: write cycles never consume a byte
  a_r5_no_pop_on_write: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |-> !strm_pop);

  // R6: RAM select and data drive never overlap
  a_r6_sel_excl: assert property (@(posedge clk) disable iff (rst)
    !(ram_sel && drive_en));

endmodule

// File: tb/test_fifo_boot_bridge.sv
`timescale 1ns/100ps
module test_fifo_boot_bridge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b1;
  logic        strm_valid = 1'b0;
  logic [7:0]  strm_data = '0;
  logic        strm_pop, cpu_ready, drive_en, ram_sel;
  logic [7:0]  bus_dout;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fifo_boot_bridge i_fifo_boot_bridge (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .strm_valid(strm_valid), .strm_data(strm_data), .strm_pop(strm_pop),
    .cpu_ready(cpu_ready), .bus_dout(bus_dout), .drive_en(drive_en),
    .ram_sel(ram_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle: drive, check combinational outputs, then registered ones
  task automatic cyc(input logic [15:0] a, input logic rd, input logic v,
                     input logic [7:0] d, input string req,
                     output logic [7:0] got);
    logic exp_pop, exp_cs;
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; strm_valid = v; strm_data = d;
    exp_pop = rd && (a >= 16'hC000) && v;
    exp_cs  = (a >= 16'h8000) && (a <= 16'hBFFF);
    #0.5;
    chk({req, " R2 ready"}, int'(cpu_ready), int'(v));
    chk({req, " R3 pop"}, int'(strm_pop), int'(exp_pop));
    @(posedge clk); #1;
    chk({req, " R5 drive"}, int'(drive_en), int'(exp_pop));
    chk({req, " R6 sel"}, int'(ram_sel), int'(exp_cs));
    if (exp_pop) chk({req, " R4 data"}, int'(bus_dout), int'(d));
    got = bus_dout;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] g, lo, hi;
    logic [15:0] vec;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk("R1 drive", int'(drive_en), 0);
    chk("R1 sel", int'(ram_sel), 0);
    chk("R1 dout", int'(bus_dout), 0);
    @(negedge clk); rst = 1'b0;
    cpu_addr = 16'h0000; cpu_rd = 1'b1; strm_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1 after drive", int'(drive_en), 0);
    chk("R1 after sel", int'(ram_sel), 0);

    // full read sweep with a byte queued
    for (int i = 0; i < 65536; i++)
      cyc(16'(i), 1'b1, 1'b1, 8'(i) ^ 8'h5A, "sweep-rd", g);
    // write sweep, R5: writes never pop
    for (int i = 0; i < 65536; i += 4)
      cyc(16'(i), 1'b0, 1'b1, 8'h33, "sweep-wr R5", g);
    // empty-stream read sweep, R7
    for (int i = 0; i < 65536; i += 16)
      cyc(16'(i), 1'b1, 1'b0, 8'h77, "sweep-empty R7", g);

    // R7: stall, then release pops exactly once
    for (int k = 0; k < 3; k++)
      cyc(16'hFFF0, 1'b1, 1'b0, 8'h11, "stall R7", g);
    cyc(16'hFFF0, 1'b1, 1'b1, 8'h42, "release R7", g);
    chk("R7 released byte", int'(g), 8'h42);

    // R8: reset vector from stream bytes
    cyc(16'hFFFC, 1'b1, 1'b1, 8'hEA, "vec-lo R8", lo);
    cyc(16'hFFFD, 1'b1, 1'b1, 8'hEA, "vec-hi R8", hi);
    vec = {hi, lo};
    chk("R8 vector", int'(vec), 16'hEAEA);
    cyc(vec, 1'b1, 1'b1, 8'hA9, "vec-fetch R8", g);
    chk("R8 first opcode", int'(g), 8'hA9);

    // R9: store operands, write cycle leaves queued opcode
    cyc(16'hC000, 1'b1, 1'b1, 8'h9D, "st-op R9", g);
    cyc(16'hC001, 1'b1, 1'b1, 8'h00, "st-lo R9", g);
    cyc(16'hC002, 1'b1, 1'b1, 8'h80, "st-hi R9", g);
    cyc(16'h8005, 1'b0, 1'b1, 8'h4C, "st-wr R9", g);
    chk("R9 no drive after write", int'(drive_en), 0);
    cyc(16'hC003, 1'b1, 1'b1, 8'h4C, "next-op R9", g);
    chk("R9 queued opcode", int'(g), 8'h4C);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule